// File: doc/BRIEF.md
# Decoded I/O Output Write Port

This block is a data-sink slave on a shared parallel bus with a single master. Each bus cycle presents an address, a two-bit function code and a strobe. The block decodes the cycle in two stages. The first stage compares the address with the one port address. When that matches, it enables the second stage, which checks that the function is an I/O write. When both stages match while the strobe is valid, the byte on the data bus is loaded into an output register. That register drives the external port pins and keeps its value until the next accepted write.

The block returns an acknowledge to the master one clock after a matching strobe. The acknowledge drops one clock after the strobe goes away. The block only receives data and never drives the data bus. A typical use is to let software step a pattern, such as a walking one, across a set of output lines.

Function codes on the two-bit function input: 2'b00 memory read, 2'b01 memory write, 2'b10 I/O read, 2'b11 I/O write. The default port address is 0x10.

Top module: `io_out_port`

## Requirements
- R1: While the synchronous reset is high at a clock edge, the output register clears to 0x00 and the acknowledge clears to 0 from that edge on.
- R2: At a clock edge where the strobe is high, the address equals the port address (0x10), and the function is I/O write (2'b11), the output register loads the data bus. The new value is visible on the port pins after that edge.
- R3: A strobed cycle at any address other than the port address leaves the port pins unchanged, whatever its function.
- R4: A strobed cycle at the port address with function memory read (2'b00), memory write (2'b01) or I/O read (2'b10) leaves the port pins unchanged.
- R5: While the strobe is low, no address, function or data value changes the port pins.
- R6: The acknowledge is high in the clock cycle that follows each edge with a matching strobed I/O write. It stays high for as long as the matching strobe is held.
- R7: The acknowledge is low in the cycle that follows any edge without a matching strobed I/O write. In particular, it falls one clock after the strobe is released and is never raised by a non-matching cycle.
- R8: Between accepted writes, the port pins hold the last written value across any number of idle or non-matching cycles.
- R9: A sequence of I/O writes of 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40 and 0x80 makes each value appear on the pins in turn, each right after its own write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (8) | Address driven by the master |
| bus_func | input | 2 | Cycle function code (see encoding above) |
| bus_strobe | input | 1 | High while the address, function and data are valid |
| bus_data | input | DATA_W (8) | Write data from the master |
| bus_ack | output | 1 | Acknowledge back to the master |
| port_out | output | DATA_W (8) | Registered output port pins |

## Verification
The bench builds the block with its defaults: an 8-bit address, an 8-bit data path and the port at 0x10. With these values, the random stimulus can reach every one of the 256 addresses, including the ones that differ from 0x10 by a single bit, and all four function codes, each with and without the strobe. The random address is biased toward 0x10 so that accepted writes and rejected functions at the port address both occur often. The 8-bit data width makes the walking-one pattern a full sweep of every pin. Directed runs add a strobe held over several cycles, a reset taken while the port holds a value, and long idle stretches between writes.

// File: rtl/io_out_port.sv
module io_out_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_func,
  input  logic              bus_strobe,
  input  logic [DATA_W-1:0] bus_data,
  output logic              bus_ack,
  output logic [DATA_W-1:0] port_out
);

  localparam logic [1:0] FN_IO_WR = 2'b11;

  logic              addr_sel;
  logic              wr_sel;
  logic [DATA_W-1:0] port_q;
  logic              ack_q;

  // first stage: address match enables the function stage
  assign addr_sel = (bus_addr == PORT_ADDR);
  assign wr_sel   = addr_sel & bus_strobe & (bus_func == FN_IO_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= wr_sel;
      if (wr_sel) port_q <= bus_data;
    end
  end

  assign port_out = port_q;
  assign bus_ack  = ack_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (port_out == '0) && !bus_ack);

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && bus_addr == PORT_ADDR && bus_func == 2'b11)
      |=> port_out == $past(bus_data));

  assert_no_strobe_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_strobe |=> $stable(port_out));

  assert_other_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != PORT_ADDR) |=> $stable(port_out));

  assert_other_func_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_func != 2'b11) |=> $stable(port_out));

  assert_ack_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && bus_addr == PORT_ADDR && bus_func == 2'b11) |=> bus_ack);

  assert_ack_fall_R7: assert property (@(posedge clk) disable iff (rst)
    !bus_strobe |=> !bus_ack);

endmodule

// File: tb/tb_io_out_port.sv
module tb_io_out_port;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] bus_addr;
  logic [1:0] bus_func;
  logic       bus_strobe;
  logic [7:0] bus_data;
  logic       bus_ack;
  logic [7:0] port_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] exp_port;
  logic       exp_ack;

  io_out_port dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_func(bus_func),
    .bus_strobe(bus_strobe), .bus_data(bus_data),
    .bus_ack(bus_ack), .port_out(port_out)
  );

  always #5 clk = ~clk;

  function automatic bit is_hit(logic [7:0] a, logic [1:0] f, logic s);
    return s && (a == 8'h10) && (f == 2'b11);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, clock edge in between, check at following negedge
  task automatic cycle(logic [7:0] a, logic [1:0] f, logic s, logic [7:0] d,
                       string req);
    bus_addr = a; bus_func = f; bus_strobe = s; bus_data = d;
    if (is_hit(a, f, s)) exp_port = d;
    exp_ack = is_hit(a, f, s);
    @(negedge clk);
    check({req, " port"}, port_out, exp_port);
    check({req, " ack"}, bus_ack, exp_ack);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4371));
    rst = 1'b1; bus_addr = '0; bus_func = '0; bus_strobe = 0; bus_data = 8'hff;
    exp_port = 8'h00; exp_ack = 0;
    @(negedge clk); @(negedge clk);
    check("R1 reset port", port_out, 8'h00);
    check("R1 reset ack", bus_ack, 1'b0);
    rst = 1'b0;

    // R9 walking one, with idle cycles checking hold (R8) and ack fall (R7)
    for (int i = 0; i < 8; i++) begin
      cycle(8'h10, 2'b11, 1'b1, 8'h01 << i, "R9/R2/R6 walk write");
      cycle(8'h10, 2'b11, 1'b0, 8'h5a, "R7/R5 release");
      cycle(8'h00, 2'b00, 1'b0, 8'h00, "R8 idle hold");
    end

    // R4 other functions at the port address
    for (int f = 0; f < 3; f++)
      cycle(8'h10, f[1:0], 1'b1, 8'h3c, "R4 wrong function");

    // R3 neighbouring addresses
    for (int b = 0; b < 8; b++)
      cycle(8'h10 ^ (8'h01 << b), 2'b11, 1'b1, 8'hc3, "R3 wrong address");

    // R6 strobe held for several cycles, ack stays high
    for (int k = 0; k < 3; k++)
      cycle(8'h10, 2'b11, 1'b1, 8'h77, "R6 held strobe");
    cycle(8'h10, 2'b11, 1'b0, 8'h11, "R7 ack fall after hold");

    // R1 reset taken while the port holds a value
    rst = 1'b1; bus_strobe = 0;
    @(negedge clk);
    exp_port = 8'h00; exp_ack = 0;
    check("R1 mid-run reset port", port_out, 8'h00);
    check("R1 mid-run reset ack", bus_ack, 1'b0);
    rst = 1'b0;

    // random mix, address biased to the port
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] a;
      a = ($urandom % 2) ? 8'h10 : 8'($urandom);
      cycle(a, 2'($urandom), 1'($urandom), 8'($urandom), "R2-R8 random");
    end

    // long idle stretch keeps the last value
    for (int k = 0; k < 20; k++)
      cycle(8'($urandom), 2'($urandom), 1'b0, 8'($urandom), "R8 long hold");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule